// File: doc/BRIEF.md
# Frequency Sum and Difference Synthesizer

This block accepts two free-running digital pulse trains, each nominally close to 100 kHz. It measures how often each one toggles, using a fast system clock as the time base. It then regenerates two square waves from phase accumulators: one at the sum of the two input rates and one at their difference. The inputs are counted and the outputs rebuilt, rather than mixed edge against edge. As a result, duty cycle and relative phase of the inputs have no bearing on the result.

Each input passes through a synchronizer and a rising-edge detector. A gate timer of `GATE_CYC` system-clock cycles sets the counting window. At every gate boundary the counts are latched, and the two tuning words are recomputed from them as a pair. Each tuning word is the count times the constant `STEP = floor(2^ACC_W / GATE_CYC)`. A word is capped at `2^(ACC_W-1)`, which is one output edge every second clock.

When the second input is faster than the first, a mode pin chooses what the difference output does. It can either freeze at 0 Hz or run at the magnitude of the difference. A parameter can instead make one measurement unit alternate between the two channels. In that case each channel's count is held while the other one is measured.

Top module: `freq_sumdiff_synth`

## Requirements
- R1: After reset, `sum_out`, `diff_out`, `meas_a`, `meas_b` and `meas_vld` are all 0 until the first gate interval has completed.
- R2: With `SHARED=0`, at every gate boundary `meas_a` and `meas_b` take the number of rising edges seen on `in_a` and `in_b` during the `GATE_CYC` cycles just ended.
- R3: `meas_vld` is a single-cycle pulse, and consecutive pulses are exactly `GATE_CYC` cycles apart. An input change is fully reflected after one complete gate.
- R4: `sum_out` has a rising-edge rate of `min((meas_a+meas_b)*STEP, 2^(ACC_W-1)) / 2^ACC_W` per clock.
- R5: When `meas_a >= meas_b`, `diff_out` has a rate of `min((meas_a-meas_b)*STEP, 2^(ACC_W-1)) / 2^ACC_W` per clock.
- R6: When `abs_mode=0` and `meas_b > meas_a`, the difference tuning word is 0 and `diff_out` does not toggle.
- R7: When `abs_mode=1` and `meas_b > meas_a`, `diff_out` runs at the rate given by `meas_b-meas_a`.
- R8: An input held low measures 0. The sum output then follows the other input alone, and the difference output follows R5 to R7.
- R9: No tuning word exceeds `2^(ACC_W-1)`. A saturated output toggles every clock, which gives one rising edge per two cycles.
- R10: With `SHARED=1`, a single counter serves `in_a` and `in_b` on alternate gates, starting with `in_a`. Each channel's result is held until that channel is measured again.
- R11: Both tuning words change only in the cycle right after a `meas_vld` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_a | input | 1 | First asynchronous pulse train |
| in_b | input | 1 | Second asynchronous pulse train |
| abs_mode | input | 1 | 1: magnitude of a negative difference, 0: clamp it to 0 Hz |
| sum_out | output | 1 | Square wave at the sum rate |
| diff_out | output | 1 | Square wave at the difference rate |
| meas_a | output | CNT_W | Latched edge count of `in_a` per gate |
| meas_b | output | CNT_W | Latched edge count of `in_b` per gate |
| meas_vld | output | 1 | One-cycle pulse when the counts are latched |

## Verification
A gate counter that drifts off its period shows up as a `meas_vld` spacing other than `GATE_CYC`, which is visible at the second pulse. An edge counter that loses or double-counts a cycle shows up as a wrong count on `meas_a` or `meas_b` at the first clean gate boundary, at most two gates after the stimulus changes. Errors in the scaling, the sign rule or the saturation leave the counts correct. They distort only the output edge rates, which become visible within a window of a couple of thousand cycles once the words have been loaded. A stale or mixed word pair appears as an output rate that matches neither the old nor the new counts.

// File: rtl/fms_pkg.sv
package fms_pkg;

  typedef enum logic {
    NEG_CLAMP = 1'b0,
    NEG_ABS   = 1'b1
  } neg_mode_e;

  function automatic int unsigned fms_cnt_width(input int unsigned gate);
    return $clog2(gate + 1);
  endfunction

endpackage

// File: rtl/fms_edge_sync.sv
module fms_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [2:0] shr_q;
  logic [2:0] shr_nx;

  always_comb begin
    shr_nx = {shr_q[1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr_q <= '0;
    else        shr_q <= shr_nx;
  end

  assign rise = shr_q[1] & ~shr_q[2];

endmodule

// File: rtl/fms_meter.sv
module fms_meter #(
  parameter int unsigned GATE_CYC = 125000,
  parameter int unsigned CNT_W    = 17,
  parameter int unsigned SHARED   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rise,
  output logic [CNT_W-1:0] meas_a,
  output logic [CNT_W-1:0] meas_b,
  output logic             vld
);

  localparam int unsigned GW = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1;

  logic [GW-1:0] gcnt_q;
  logic [GW-1:0] gcnt_nx;
  logic          gate_end;
  logic          vld_q;

  assign gate_end = (gcnt_q == GW'(GATE_CYC - 1));

  always_comb begin
    gcnt_nx = gate_end ? '0 : gcnt_q + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      gcnt_q <= gcnt_nx;
      vld_q  <= gate_end;
    end
  end

  assign vld = vld_q;

  generate
    if (SHARED == 0) begin : g_dedicated
      logic [1:0][CNT_W-1:0] cnt_q, cnt_nx, res_q, res_nx;

      always_comb begin
        for (int i = 0; i < 2; i++) begin
          cnt_nx[i] = gate_end ? '0 : cnt_q[i] + CNT_W'(rise[i]);
          res_nx[i] = gate_end ? cnt_q[i] + CNT_W'(rise[i]) : res_q[i];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          res_q <= '0;
        end else begin
          cnt_q <= cnt_nx;
          res_q <= res_nx;
        end
      end

      assign meas_a = res_q[0];
      assign meas_b = res_q[1];
    end else begin : g_shared
      logic             sel_q, sel_nx;
      logic [CNT_W-1:0] cnt_q, cnt_nx, tot;
      logic [CNT_W-1:0] ra_q, ra_nx, rb_q, rb_nx;

      always_comb begin
        tot    = cnt_q + CNT_W'(rise[sel_q]);
        cnt_nx = gate_end ? '0 : tot;
        sel_nx = gate_end ? ~sel_q : sel_q;
        ra_nx  = (gate_end && !sel_q) ? tot : ra_q;
        rb_nx  = (gate_end &&  sel_q) ? tot : rb_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sel_q <= 1'b0;
          cnt_q <= '0;
          ra_q  <= '0;
          rb_q  <= '0;
        end else begin
          sel_q <= sel_nx;
          cnt_q <= cnt_nx;
          ra_q  <= ra_nx;
          rb_q  <= rb_nx;
        end
      end

      assign meas_a = ra_q;
      assign meas_b = rb_q;
    end
  endgenerate

endmodule

// File: rtl/fms_word_calc.sv
module fms_word_calc
  import fms_pkg::*;
#(
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned CNT_W    = 17,
  parameter int unsigned GATE_CYC = 125000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  neg_mode_e        neg_mode,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic [ACC_W-1:0] sum_word,
  output logic [ACC_W-1:0] diff_word
);

  localparam int unsigned PW = ACC_W + CNT_W + 2;
  localparam logic [PW-1:0] STEP = PW'((64'd1 << ACC_W) / 64'(GATE_CYC));
  localparam logic [PW-1:0] CAP  = PW'(64'd1 << (ACC_W - 1));

  function automatic logic [ACC_W-1:0] scale(input logic [CNT_W:0] c);
    logic [PW-1:0] prod;
    prod = PW'(c) * STEP;
    if (prod > CAP) return ACC_W'(CAP);
    else            return prod[ACC_W-1:0];
  endfunction

  logic [CNT_W:0]   sum_cnt;
  logic [CNT_W:0]   diff_cnt;
  logic [ACC_W-1:0] sw_q, sw_nx, dw_q, dw_nx;

  always_comb begin
    sum_cnt = {1'b0, cnt_a} + {1'b0, cnt_b};
    if (cnt_a >= cnt_b)          diff_cnt = {1'b0, cnt_a - cnt_b};
    else if (neg_mode == NEG_ABS) diff_cnt = {1'b0, cnt_b - cnt_a};
    else                          diff_cnt = '0;
    sw_nx = upd ? scale(sum_cnt)  : sw_q;
    dw_nx = upd ? scale(diff_cnt) : dw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      dw_q <= '0;
    end else begin
      sw_q <= sw_nx;
      dw_q <= dw_nx;
    end
  end

  assign sum_word  = sw_q;
  assign diff_word = dw_q;

endmodule

// File: rtl/fms_phase_acc.sv
module fms_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] word,
  output logic             wave
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nx;

  always_comb begin
    acc_nx = acc_q + word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nx;
  end

  assign wave = acc_q[ACC_W-1];

endmodule

// File: rtl/freq_sumdiff_synth.sv
module freq_sumdiff_synth
  import fms_pkg::*;
#(
  parameter  int unsigned GATE_CYC = 125000,
  parameter  int unsigned ACC_W    = 32,
  parameter  int unsigned SHARED   = 0,
  localparam int unsigned CNT_W    = fms_cnt_width(GATE_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             abs_mode,
  output logic             sum_out,
  output logic             diff_out,
  output logic [CNT_W-1:0] meas_a,
  output logic [CNT_W-1:0] meas_b,
  output logic             meas_vld
);

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [1:0] pin;
  logic [1:0] rise;
  assign pin = {in_b, in_a};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_sync
      fms_edge_sync u_sync (
        .clk  (clk),
        .rst_n(rst_int_n),
        .din  (pin[g]),
        .rise (rise[g])
      );
    end
  endgenerate

  fms_meter #(
    .GATE_CYC(GATE_CYC),
    .CNT_W   (CNT_W),
    .SHARED  (SHARED)
  ) u_meter (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rise  (rise),
    .meas_a(meas_a),
    .meas_b(meas_b),
    .vld   (meas_vld)
  );

  logic [ACC_W-1:0] sum_word;
  logic [ACC_W-1:0] diff_word;

  fms_word_calc #(
    .ACC_W   (ACC_W),
    .CNT_W   (CNT_W),
    .GATE_CYC(GATE_CYC)
  ) u_calc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd      (meas_vld),
    .neg_mode (neg_mode_e'(abs_mode)),
    .cnt_a    (meas_a),
    .cnt_b    (meas_b),
    .sum_word (sum_word),
    .diff_word(diff_word)
  );

  logic [1:0][ACC_W-1:0] words;
  logic [1:0]            waves;
  assign words = {diff_word, sum_word};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_acc
      fms_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_int_n),
        .word (words[g]),
        .wave (waves[g])
      );
    end
  endgenerate

  assign sum_out  = waves[0];
  assign diff_out = waves[1];

endmodule

// File: rtl/fms_chk.sv
module fms_chk #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_vld,
  input logic             abs_mode,
  input logic [CNT_W-1:0] meas_a,
  input logic [CNT_W-1:0] meas_b,
  input logic [ACC_W-1:0] sum_word,
  input logic [ACC_W-1:0] diff_word,
  input logic             sum_out,
  input logic             diff_out
);

  localparam logic [ACC_W:0] CAP = (ACC_W+1)'(1) << (ACC_W - 1);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (meas_vld) seen_q <= 1'b1;
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!sum_out && !diff_out));

  // R9
  word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, sum_word} <= CAP) && ({1'b0, diff_word} <= CAP));

  // R6
  neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && !abs_mode && (meas_b > meas_a)) |=> (diff_word == '0));

  // R7
  neg_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && abs_mode && (meas_b > meas_a)) |=> (diff_word != '0));

  // R11
  word_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sum_word) || !$stable(diff_word)) |-> $past(meas_vld));

  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> !meas_vld);

endmodule

bind freq_sumdiff_synth fms_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .meas_vld (meas_vld),
  .abs_mode (abs_mode),
  .meas_a   (meas_a),
  .meas_b   (meas_b),
  .sum_word (sum_word),
  .diff_word(diff_word),
  .sum_out  (sum_out),
  .diff_out (diff_out)
);

// File: tb/sim_freq_sumdiff_synth.sv
`timescale 1ns/1ps
module sim_freq_sumdiff_synth;

  localparam int unsigned G     = 1000;
  localparam int unsigned AW    = 32;
  localparam int unsigned CW    = $clog2(G + 1);
  localparam int          WIN   = 2000;
  localparam longint      STEPV = (64'd1 << AW) / G;
  localparam longint      CAPV  = 64'd1 << (AW - 1);

  logic clk, rst_n, in_a, in_b, abs_mode;
  logic sum_o, diff_o, vld0;
  logic [CW-1:0] ma0, mb0;
  logic sum1, diff1, vld1;
  logic [CW-1:0] ma1, mb1;

  int checks = 0;
  int fails  = 0;
  int pa = 0;
  int pb = 0;
  int ca = 0;
  int cb = 0;

  freq_sumdiff_synth #(.GATE_CYC(G), .ACC_W(AW), .SHARED(0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .abs_mode(abs_mode),
    .sum_out(sum_o), .diff_out(diff_o), .meas_a(ma0), .meas_b(mb0), .meas_vld(vld0));

  freq_sumdiff_synth #(.GATE_CYC(G), .ACC_W(AW), .SHARED(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .abs_mode(abs_mode),
    .sum_out(sum1), .diff_out(diff1), .meas_a(ma1), .meas_b(mb1), .meas_vld(vld1));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    in_a = 1'b0;
    in_b = 1'b0;
    forever begin
      @(negedge clk);
      if (pa == 0) begin in_a = 1'b0; ca = 0; end
      else begin ca = (ca + 1 >= pa) ? 0 : ca + 1; in_a = (ca < pa / 2); end
      if (pb == 0) begin in_b = 1'b0; cb = 0; end
      else begin cb = (cb + 1 >= pb) ? 0 : cb + 1; in_b = (cb < pb / 2); end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_edges(input longint cnt);
    longint w;
    w = cnt * STEPV;
    if (w > CAPV) w = CAPV;
    return (longint'(WIN) * w) >> AW;
  endfunction

  task automatic wait_vld();
    do @(negedge clk); while (!vld0);
  endtask

  task automatic settle();
    repeat (3) wait_vld();
    repeat (4) @(negedge clk);
  endtask

  task automatic count_edges(output int ns, output int nd);
    logic ps, pd;
    ns = 0; nd = 0;
    ps = sum_o; pd = diff_o;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (sum_o && !ps)  ns++;
      if (diff_o && !pd) nd++;
      ps = sum_o; pd = diff_o;
    end
  endtask

  task automatic near(input string req, input int act, input longint exp, input int tol);
    chk((act >= exp - tol) && (act <= exp + tol), req, act, exp);
  endtask

  task automatic t_reset();
    bit bad;
    bad = 0;
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      if (sum_o || diff_o || vld0 || ma0 != 0 || mb0 != 0) bad = 1;
    end
    chk(!bad, "R1 idle after reset", bad, 0);
  endtask

  task automatic t_pattern(input int p_a, input int p_b, input bit absm,
                           input longint ea, input longint eb, input longint es,
                           input longint ed, input int dtol, input string tag);
    int ns, nd;
    pa = p_a; pb = p_b; abs_mode = absm;
    settle();
    chk(ma0 == ea, {"R2 meas_a ", tag}, ma0, ea);
    chk(mb0 == eb, {"R2 meas_b ", tag}, mb0, eb);
    count_edges(ns, nd);
    near({"R4 sum rate ", tag}, ns, es, 2);
    near({"R5/R6/R7 diff rate ", tag}, nd, ed, dtol);
  endtask

  task automatic t_gate_spacing();
    int n;
    wait_vld();
    n = 0;
    do begin @(negedge clk); n++; end while (!vld0);
    chk(n == G, "R3 gate spacing", n, G);
  endtask

  task automatic t_shared();
    pa = 10; pb = 20; abs_mode = 1'b0;
    settle();
    wait_vld();
    chk(ma1 == 100, "R10 shared meas_a", ma1, 100);
    chk(mb1 == 50,  "R10 shared meas_b", mb1, 50);
    pa = 0;
    do @(negedge clk); while (!vld1);
    do @(negedge clk); while (!vld1);
    do @(negedge clk); while (!vld1);
    chk((ma1 == 0 && mb1 == 50) || (ma1 == 100 && mb1 == 50), "R10 hold across gates", mb1, 50);
    pa = 10;
  endtask

  initial begin
    rst_n = 1'b0;
    abs_mode = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    pa = 10; pb = 20;
    t_reset();
    t_gate_spacing();
    // R4 R5: 100 and 50 edges per gate
    t_pattern(10, 20, 1'b0, 100, 50, exp_edges(150), exp_edges(50), 2, "basic");
    // close rates 125 and 100
    t_pattern(8, 10, 1'b0, 125, 100, exp_edges(225), exp_edges(25), 2, "close");
    // R6 negative difference clamped: diff frozen
    t_pattern(20, 10, 1'b0, 50, 100, exp_edges(150), 0, 0, "R6 clamp");
    // R7 negative difference magnitude
    t_pattern(20, 10, 1'b1, 50, 100, exp_edges(150), exp_edges(50), 2, "R7 abs");
    // R8 second input stopped
    t_pattern(10, 0, 1'b0, 100, 0, exp_edges(100), exp_edges(100), 2, "R8 stop b");
    // R8 first input stopped with clamp
    t_pattern(0, 8, 1'b0, 0, 125, exp_edges(125), 0, 0, "R8 stop a");
    // R9 saturation of sum word
    t_pattern(4, 2, 1'b1, 250, 500, exp_edges(750), exp_edges(250), 2, "R9 sat");
    chk(exp_edges(750) == WIN / 2, "R9 cap model", exp_edges(750), WIN / 2);
    t_shared();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule